// File: doc/BRIEF.md
# Folded Programmable-Depth Tap Delay Line

This block holds the sample history for a folded FIR filter whose coefficients are symmetric. Samples enter a forward chain of eight stages and move left to right. At the far end they turn around into a reverse chain of eight stages that moves them right to left. Each forward tap is meant to be paired with a reverse tap in an external pre-adder, so one multiplier serves two taps. The pre-adders, multipliers and output decimation sit outside this block.

Each stage is a delay of L clocks, with L programmable from 1 to 16, rather than a single register. Setting L to the number of data sets interleaved in one stream keeps each set's history separate. Setting L to a decimation factor N lets a filter whose output is read once every N clocks use 16N taps. A single non-interleaved stream with no decimation uses L = 1. A tap-parity input picks the turnaround point. In even mode the last forward stage's output feeds the reverse chain. In odd mode the turnaround takes the value that the last forward stage will present one clock later, so the centre sample is used once.

Top module: `fold_delay_line`

## Requirements
- R1: While `rst_n` is low, every forward and reverse tap reads zero, and the stored stage length is 1.
- R2: `len` encodes the stage delay L. The value 0 means 16, and the values 1 to 15 mean themselves. Forward tap k occupies bits [k*W +: W] of `fwd_taps`, and reverse tap j occupies bits [j*W +: W] of `rev_taps`.
- R3: With an unchanged `len` and no clear, forward tap k (k = 0..7) shows the `din` value sampled (k+1)*L clock edges earlier.
- R4: In even mode (`odd_tap` = 0), reverse tap j (j = 0..7) shows the `din` value sampled (9+j)*L edges earlier, which is the last forward tap's output delayed by (j+1)*L.
- R5: In odd mode (`odd_tap` = 1), reverse tap j shows the `din` value sampled (9+j)*L - 1 edges earlier.
- R6: A clock edge with `clr` high zeroes the contents of all stages. The `din` value at that edge is discarded.
- R7: A clock edge at which `len` differs from the stored length zeroes all stages, discards `din`, and adopts the new length.
- R8: A change of `odd_tap` alone does not clear stage contents. The forward taps continue to follow R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all stage contents |
| len | input | 4 | Stage delay code, 0 means 16 |
| odd_tap | input | 1 | 1 selects odd-tap turnaround, 0 selects even |
| din | input | W | Input sample |
| fwd_taps | output | 8*W | Forward stage outputs, tap 0 in the low bits |
| rev_taps | output | 8*W | Reverse stage outputs, tap 0 in the low bits |

## Verification
A corrupted delay element appears at its stage's own tap within L clocks. It then reappears on every later tap, one stage delay further on each. A wrong turnaround choice surfaces first on reverse tap 0, as a sample offset by one clock from the expected value. That mismatch becomes visible within L clocks of the first valid sample reaching the end of the forward chain. A missed clear or length-change wipe leaves stale nonzero samples on the taps at the very next sample point, where zeros are expected.

// File: rtl/fold_delay_line.sv
module fold_delay_line #(
  parameter int W    = 8,
  parameter int NTAP = 8,
  parameter int MAXD = 16,
  localparam int LW  = $clog2(MAXD),
  localparam int NST = 2 * NTAP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [LW-1:0]     len,
  input  logic              odd_tap,
  input  logic [W-1:0]      din,
  output logic [NTAP*W-1:0] fwd_taps,
  output logic [NTAP*W-1:0] rev_taps
);

  logic [W-1:0]  mem  [NST][MAXD];
  logic [W-1:0]  sin  [NST];
  logic [W-1:0]  sout [NST];
  logic [W-1:0]  turn;
  logic [LW-1:0] len_q;
  logic [LW:0]   depth;
  logic [LW-1:0] idx;
  logic          wipe;

  assign depth = (len_q == '0) ? (LW+1)'(MAXD) : {1'b0, len_q};
  assign idx   = LW'(depth - 1'b1);
  assign wipe  = clr || (len != len_q);

  always_comb begin
    if (!odd_tap)        turn = sout[NTAP-1];
    else if (depth == 1) turn = sin[NTAP-1];
    else                 turn = mem[NTAP-1][LW'(depth - 2'd2)];
  end

  generate
    for (genvar s = 0; s < NST; s++) begin : g_link
      assign sout[s] = mem[s][idx];
      if (s == 0)         begin : g_head assign sin[s] = din;        end
      else if (s == NTAP) begin : g_turn assign sin[s] = turn;       end
      else                begin : g_next assign sin[s] = sout[s-1];  end
    end
    for (genvar k = 0; k < NTAP; k++) begin : g_out
      assign fwd_taps[k*W +: W] = sout[k];
      assign rev_taps[k*W +: W] = sout[NTAP+k];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= LW'(1);
      for (int s = 0; s < NST; s++)
        for (int i = 0; i < MAXD; i++) mem[s][i] <= '0;
    end else begin
      len_q <= len;
      for (int s = 0; s < NST; s++) begin
        if (wipe) begin
          for (int i = 0; i < MAXD; i++) mem[s][i] <= '0;
        end else begin
          mem[s][0] <= sin[s];
          for (int i = 1; i < MAXD; i++) mem[s][i] <= mem[s][i-1];
        end
      end
    end
  end

  p_clr_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (fwd_taps == '0 && rev_taps == '0));

  p_len_wipe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (len != len_q) |=> (fwd_taps == '0 && rev_taps == '0 && len_q == $past(len)));

  p_fwd_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wipe && len_q == LW'(1)) |=> (sout[1] == $past(sout[0]) && sout[0] == $past(din)));

  p_even_turn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wipe && len_q == LW'(1) && !odd_tap) |=> (sout[NTAP] == $past(sout[NTAP-1])));

  p_odd_turn_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wipe && len_q == LW'(1) && odd_tap) |=> (sout[NTAP] == $past(sout[NTAP-2])));

  p_rev_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wipe && len_q == LW'(1)) |=> (sout[NTAP+1] == $past(sout[NTAP])));

endmodule

// File: tb/fold_delay_line_test.sv
module fold_delay_line_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int NT = 8;
  localparam int HN = 272;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clr = 1'b0;
  logic [3:0]    len = 4'd1;
  logic          odd_tap = 1'b0;
  logic [W-1:0]  din = '0;
  logic [NT*W-1:0] fwd_taps, rev_taps;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  logic [W-1:0] h [HN];
  logic [3:0] plen = 4'd1;

  // {len, odd, steps}
  localparam logic [15:0] VEC [8] = '{
    {4'd1,  1'b0, 11'd40},
    {4'd1,  1'b1, 11'd40},
    {4'd2,  1'b0, 11'd60},
    {4'd3,  1'b1, 11'd70},
    {4'd5,  1'b0, 11'd120},
    {4'd0,  1'b1, 11'd300},
    {4'd15, 1'b0, 11'd290},
    {4'd4,  1'b1, 11'd90}
  };

  fold_delay_line uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .len(len), .odd_tap(odd_tap),
    .din(din), .fwd_taps(fwd_taps), .rev_taps(rev_taps)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int dl(input logic [3:0] l);
    return (l == 4'd0) ? 16 : int'(l);
  endfunction

  task automatic model_zero();
    for (int i = 0; i < HN; i++) h[i] = '0;
  endtask

  task automatic compare(input bit chk_rev, input string tag);
    int L;
    logic [W-1:0] e, a;
    bit bad;
    L = dl(len);
    bad = 0;
    for (int k = 0; k < NT; k++) begin
      e = h[(k+1)*L-1];
      a = fwd_taps[k*W +: W];
      if (a !== e) begin
        bad = 1;
        $display("FAIL %s R3 fwd tap %0d: actual %0h expected %0h", tag, k, a, e);
      end
      if (chk_rev) begin
        e = odd_tap ? h[(9+k)*L-2] : h[(9+k)*L-1];
        a = rev_taps[k*W +: W];
        if (a !== e) begin
          bad = 1;
          $display("FAIL %s %s rev tap %0d: actual %0h expected %0h",
                   tag, odd_tap ? "R5" : "R4", k, a, e);
        end
      end
    end
    tests++;
    if (bad) fails++;
  endtask

  task automatic step(input logic [W-1:0] d, input logic c, input bit chk_rev,
                      input string tag);
    din = d;
    clr = c;
    @(posedge clk);
    if (c || len != plen) model_zero();
    else begin
      for (int i = HN-1; i > 0; i--) h[i] = h[i-1];
      h[0] = d;
    end
    plen = len;
    @(negedge clk);
    clr = 1'b0;
    compare(chk_rev, tag);
  endtask

  task automatic all_zero(input string tag);
    tests++;
    if (fwd_taps !== '0 || rev_taps !== '0) begin
      fails++;
      $display("FAIL %s: actual %0h/%0h expected 0/0", tag, fwd_taps, rev_taps);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    model_zero();
    repeat (3) @(negedge clk);
    all_zero("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    all_zero("R1 after reset");

    for (int r = 0; r < 8; r++) begin
      len = VEC[r][15:12];
      odd_tap = VEC[r][11];
      step(8'hFF, 1'b1, 1, "R6 row clear");
      for (int n = 0; n < int'(VEC[r][10:0]); n++)
        step(8'(n*37 + r*11 + 1), 1'b0, 1, (VEC[r][15:12] == 0) ? "R2 len0" : "R2 table");
    end

    len = 4'd2; odd_tap = 1'b0;
    for (int n = 0; n < 50; n++) step(8'(n + 100), 1'b0, 1, "R4 fill");
    step(8'hAA, 1'b1, 1, "R6 clear");
    all_zero("R6 clear wipes");
    for (int n = 0; n < 40; n++) step(8'(n*3 + 7), 1'b0, 1, "R6 refill");

    len = 4'd3;
    step(8'h55, 1'b0, 1, "R7 len change");
    all_zero("R7 len change wipes");
    for (int n = 0; n < 80; n++) step(8'(n*13 + 2), 1'b0, 1, "R7 new len");

    odd_tap = 1'b1;
    for (int n = 0; n < 10; n++) step(8'(n + 200), 1'b0, 0, "R8 odd toggle");
    tests++;
    if (fwd_taps === '0) begin
      fails++;
      $display("FAIL R8 taps cleared: actual %0h expected nonzero", fwd_taps);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule